// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display panel that takes one pixel per clock. A set of configuration inputs describes the frame: active width and height, horizontal and vertical totals, the distance from the start of sync to the first active pixel on each axis, and the sync pulse widths. From these the block runs a horizontal pixel counter and a vertical line counter. It drives horizontal and vertical sync, a data-enable strobe, a field flag and a start-of-line delay figure. The delay figure is derived from the number of vertical blanking lines.

The vertical total uses half-line units in progressive mode, so software writes twice the line count. In interlaced mode the total is the plain per-field line count, each field shows half the frame's active height, and the field flag alternates. The block latches the configuration into shadow registers only at a vertical wrap, so a change made mid-field never tears the current field. While the global enable is clear, all outputs rest at their inactive levels, and the shadow registers follow the inputs. Raising the enable starts the scan at pixel 0 of line 0.

Top module: `disp_timing_gen`

## Requirements
- R1: While `cfg_enable` is low (one clock after it falls), `de_o` and `field_o` are 0, `x_o` and `y_o` are 0, and each sync output sits at its inactive level (equal to its invert bit).
- R2: While running, `x_o` counts 0 up to `h_total - 1` and then returns to 0; `y_o` advances by one at each horizontal wrap.
- R3: Before polarity is applied, hsync is active while `x_o` is below the horizontal sync width, held in `cfg_sync_width[XW-1:0]`; the vertical width is in `cfg_sync_width[XW+YW-1:XW]`.
- R4: A field has `cfg_v_total / 2` lines (rounded down) in progressive mode and `cfg_v_total` lines in interlaced mode; `y_o` returns to 0 after the last line.
- R5: `de_o` is 1 exactly when `h_bp <= x_o < h_bp + h_active` and `v_bp <= y_o < v_bp + A`, where A is the active height per field.
- R6: A is `cfg_v_active` in progressive mode and `cfg_v_active / 2` in interlaced mode. `field_o` toggles at each vertical wrap in interlaced mode and stays 0 in progressive mode.
- R7: In field 0 (and in progressive mode), vsync is active for lines `y_o < vsw`. In interlaced field 1, vsync is active from pixel `floor(h_total/2)` of line 0 up to that same pixel of line `vsw`, where vsw must be at least 1.
- R8: `hsync_o` equals the active condition XOR `cfg_hsync_inv`, and `vsync_o` equals the active condition XOR `cfg_vsync_inv`; both bits clear gives active-high syncs.
- R9: `line_delay_o` is computed from B, the number of lines per field minus A, clamped at 0. B is halved (rounded down) in interlaced mode, reduced by 2 when `cfg_trim` is set, clamped at 0, and saturated at 30.
- R10: A configuration change made while running has no effect until the next vertical wrap, and takes effect from pixel 0 of the following field.
- R11: After `cfg_enable` rises, the first clock edge that samples it high leaves the scan at `x_o = 0`, `y_o = 0`, `field_o = 0`, with outputs active from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Global run enable |
| cfg_interlace | input | 1 | 1 = interlaced, 0 = progressive |
| cfg_trim | input | 1 | Subtract 2 from the line delay |
| cfg_hsync_inv | input | 1 | Invert horizontal sync |
| cfg_vsync_inv | input | 1 | Invert vertical sync |
| cfg_h_active | input | XW | Active pixels per line |
| cfg_h_total | input | XW | Pixels per line including blanking |
| cfg_h_bp | input | XW | Sync start to first active pixel |
| cfg_v_active | input | YW | Active lines per frame |
| cfg_v_total | input | YW | Vertical total (half-lines when progressive) |
| cfg_v_bp | input | YW | Sync start to first active line |
| cfg_sync_width | input | XW+YW | Packed sync widths: horizontal low, vertical high |
| x_o | output | XW | Pixel counter |
| y_o | output | YW | Line counter within the field |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field, interlaced mode |
| line_delay_o | output | 5 | Start-of-line delay in lines |

## Verification
Two events can fall on the same clock edge: the vertical wrap that ends a field, and the shadow load that adopts a new configuration. The bench changes the configuration in the middle of a progressive field and keeps predicting the old geometry until its own model reaches the wrap. It then expects the new geometry, polarity and delay from pixel 0 of the next field. Any cycle in which the output position, syncs, data enable or delay leaves that prediction counts as a miscompare. A second such collision happens when the enable falls mid-frame and rises again right away: the counters must clear and then restart from the origin.

// File: rtl/dtg_pkg.sv
// Shared constants and helpers for the raster timing generator.
// Assumes nothing beyond 1800-2017 package semantics.
package dtg_pkg;

    localparam int DTG_DELAY_W   = 5;   // width of the line-delay output
    localparam int DTG_DELAY_CAP = 30;  // saturation ceiling of the line delay
    localparam int DTG_TRIM      = 2;   // subtraction applied by the trim bit

    // Index of each sync signal inside the polarity stage.
    typedef enum int {
        SYNC_H = 0,
        SYNC_V = 1
    } sync_sel_e;

    localparam int DTG_NSYNC = 2;

endpackage

// File: rtl/dtg_shadow.sv
// Shadow copy of the timing configuration.
// Captures the configuration inputs whenever load is high; the top raises
// load while idle and at every vertical wrap, so a running field always sees
// a frozen set of values.
module dtg_shadow #(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          in_interlace,
    input  logic          in_trim,
    input  logic          in_hinv,
    input  logic          in_vinv,
    input  logic [XW-1:0] in_h_active,
    input  logic [XW-1:0] in_h_total,
    input  logic [XW-1:0] in_h_bp,
    input  logic [YW-1:0] in_v_active,
    input  logic [YW-1:0] in_v_total,
    input  logic [YW-1:0] in_v_bp,
    input  logic [XW-1:0] in_h_sw,
    input  logic [YW-1:0] in_v_sw,
    output logic          sh_interlace,
    output logic          sh_trim,
    output logic          sh_hinv,
    output logic          sh_vinv,
    output logic [XW-1:0] sh_h_active,
    output logic [XW-1:0] sh_h_total,
    output logic [XW-1:0] sh_h_bp,
    output logic [YW-1:0] sh_v_active,
    output logic [YW-1:0] sh_v_total,
    output logic [YW-1:0] sh_v_bp,
    output logic [XW-1:0] sh_h_sw,
    output logic [YW-1:0] sh_v_sw
);

    // Capture all configuration fields together on a load request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_interlace <= 1'b0;
            sh_trim      <= 1'b0;
            sh_hinv      <= 1'b0;
            sh_vinv      <= 1'b0;
            sh_h_active  <= '0;
            sh_h_total   <= '0;
            sh_h_bp      <= '0;
            sh_v_active  <= '0;
            sh_v_total   <= '0;
            sh_v_bp      <= '0;
            sh_h_sw      <= '0;
            sh_v_sw      <= '0;
        end else if (load) begin
            sh_interlace <= in_interlace;
            sh_trim      <= in_trim;
            sh_hinv      <= in_hinv;
            sh_vinv      <= in_vinv;
            sh_h_active  <= in_h_active;
            sh_h_total   <= in_h_total;
            sh_h_bp      <= in_h_bp;
            sh_v_active  <= in_v_active;
            sh_v_total   <= in_v_total;
            sh_v_bp      <= in_v_bp;
            sh_h_sw      <= in_h_sw;
            sh_v_sw      <= in_v_sw;
        end
    end

endmodule

// File: rtl/dtg_counter.sv
// Pixel and line counters with field tracking.
// Counters are cleared while the enable is low and for the first enabled
// cycle, so the scan restarts at the origin. Assumes h_total >= 1 and
// lines_total >= 1 while running.
module dtg_counter #(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          interlace,
    input  logic [XW-1:0] h_total,
    input  logic [YW-1:0] lines_total,
    output logic          run_q,
    output logic [XW-1:0] hcnt,
    output logic [YW-1:0] line,
    output logic          field_q,
    output logic          frame_wrap
);

    logic h_last;
    logic v_last;
    logic active;

    // End-of-line, end-of-field and running decode.
    always_comb begin
        h_last     = (hcnt == h_total - XW'(1));
        v_last     = (line == lines_total - YW'(1));
        active     = enable && run_q;
        frame_wrap = active && h_last && v_last;
    end

    // Run flag: one cycle behind the enable so the first enabled cycle shows the origin.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= enable;
    end

    // Horizontal pixel counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) hcnt <= '0;
        else if (h_last)       hcnt <= '0;
        else                   hcnt <= hcnt + XW'(1);
    end

    // Vertical line counter, advanced at each horizontal wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) line <= '0;
        else if (h_last) begin
            if (v_last) line <= '0;
            else        line <= line + YW'(1);
        end
    end

    // Field flag: alternates at each vertical wrap when interlaced.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) field_q <= 1'b0;
        else if (frame_wrap)   field_q <= interlace ? ~field_q : 1'b0;
    end

endmodule

// File: rtl/dtg_decode.sv
// Turns counter positions into sync, data-enable and field outputs.
// Sync widths and back-porch values are measured from the start of sync.
// Assumes the vertical sync width is at least 1 in interlaced mode.
module dtg_decode
    import dtg_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic          run,
    input  logic          interlace,
    input  logic          field_q,
    input  logic          hinv,
    input  logic          vinv,
    input  logic [XW-1:0] hcnt,
    input  logic [YW-1:0] line,
    input  logic [XW-1:0] h_total,
    input  logic [XW-1:0] h_active,
    input  logic [XW-1:0] h_bp,
    input  logic [XW-1:0] h_sw,
    input  logic [YW-1:0] v_active,
    input  logic [YW-1:0] v_bp,
    input  logic [YW-1:0] v_sw,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          field
);

    logic [XW:0]         h_end;
    logic [YW:0]         v_end;
    logic [YW-1:0]       field_lines;
    logic [XW-1:0]       half_line;
    logic                h_in;
    logic                v_in;
    logic                vs_late;
    logic [DTG_NSYNC-1:0] raw;
    logic [DTG_NSYNC-1:0] inv;
    logic [DTG_NSYNC-1:0] pol;

    // Active window on both axes.
    always_comb begin
        field_lines = interlace ? (v_active >> 1) : v_active;
        h_end       = {1'b0, h_bp} + {1'b0, h_active};
        v_end       = {1'b0, v_bp} + {1'b0, field_lines};
        h_in        = (hcnt >= h_bp) && ({1'b0, hcnt} < h_end);
        v_in        = (line >= v_bp) && ({1'b0, line} < v_end);
    end

    // Unpolarised sync conditions; the second field's vsync is shifted by half a line.
    always_comb begin
        half_line = h_total >> 1;
        vs_late   = ((line == '0) && (hcnt >= half_line)) ||
                    ((line != '0) && (line < v_sw)) ||
                    ((line == v_sw) && (hcnt < half_line));
        raw[SYNC_H] = (hcnt < h_sw);
        raw[SYNC_V] = (interlace && field_q) ? vs_late : (line < v_sw);
        inv[SYNC_H] = hinv;
        inv[SYNC_V] = vinv;
    end

    // Polarity and idle gating, one identical stage per sync signal.
    for (genvar s = 0; s < DTG_NSYNC; s++) begin : g_pol
        assign pol[s] = run ? (raw[s] ^ inv[s]) : inv[s];
    end

    // Output mapping with idle gating of the strobes.
    always_comb begin
        hsync = pol[SYNC_H];
        vsync = pol[SYNC_V];
        de    = run && h_in && v_in;
        field = run && field_q;
    end

endmodule

// File: rtl/dtg_delay.sv
// Start-of-line delay derived from vertical blanking of the shadow setup.
// Per-field blanking lines, halved when interlaced, optionally trimmed by
// two, clamped to zero and saturated at the ceiling.
module dtg_delay
    import dtg_pkg::*;
#(
    parameter int YW = 12
) (
    input  logic                   interlace,
    input  logic                   trim,
    input  logic [YW-1:0]          lines_total,
    input  logic [YW-1:0]          v_active,
    output logic [DTG_DELAY_W-1:0] delay
);

    localparam int SW = YW + 2;
    localparam logic signed [SW-1:0] TRIM_S = SW'(DTG_TRIM);
    localparam logic signed [SW-1:0] CAP_S  = SW'(DTG_DELAY_CAP);

    logic [YW-1:0]        act_lines;
    logic signed [SW-1:0] blank;

    // Blanking arithmetic with clamping at both ends.
    always_comb begin
        act_lines = interlace ? (v_active >> 1) : v_active;
        blank     = $signed({2'b00, lines_total}) - $signed({2'b00, act_lines});
        if (blank[SW-1]) blank = '0;
        if (interlace)   blank = blank >>> 1;
        if (trim)        blank = blank - TRIM_S;
        if (blank[SW-1]) blank = '0;
        if (blank > CAP_S) blank = CAP_S;
        delay = blank[DTG_DELAY_W-1:0];
    end

endmodule

// File: rtl/disp_timing_gen.sv
// Top of the raster timing generator.
// Shadows the configuration, runs the counters and decodes the outputs.
// The shadow reloads while idle and at each vertical wrap.
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_enable,
    input  logic                   cfg_interlace,
    input  logic                   cfg_trim,
    input  logic                   cfg_hsync_inv,
    input  logic                   cfg_vsync_inv,
    input  logic [XW-1:0]          cfg_h_active,
    input  logic [XW-1:0]          cfg_h_total,
    input  logic [XW-1:0]          cfg_h_bp,
    input  logic [YW-1:0]          cfg_v_active,
    input  logic [YW-1:0]          cfg_v_total,
    input  logic [YW-1:0]          cfg_v_bp,
    input  logic [XW+YW-1:0]       cfg_sync_width,
    output logic [XW-1:0]          x_o,
    output logic [YW-1:0]          y_o,
    output logic                   hsync_o,
    output logic                   vsync_o,
    output logic                   de_o,
    output logic                   field_o,
    output logic [DTG_DELAY_W-1:0] line_delay_o
);

    logic          run_q;
    logic          frame_wrap;
    logic          shadow_load;
    logic          field_q;
    logic          sh_interlace, sh_trim, sh_hinv, sh_vinv;
    logic [XW-1:0] sh_h_active, sh_h_total, sh_h_bp, sh_h_sw;
    logic [YW-1:0] sh_v_active, sh_v_total, sh_v_bp, sh_v_sw;
    logic [YW-1:0] lines_total;

    // Reload policy and line count (half-line total when progressive).
    always_comb begin
        shadow_load = !cfg_enable || !run_q || frame_wrap;
        lines_total = sh_interlace ? sh_v_total : (sh_v_total >> 1);
    end

    dtg_shadow #(.XW(XW), .YW(YW)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (shadow_load),
        .in_interlace (cfg_interlace),
        .in_trim      (cfg_trim),
        .in_hinv      (cfg_hsync_inv),
        .in_vinv      (cfg_vsync_inv),
        .in_h_active  (cfg_h_active),
        .in_h_total   (cfg_h_total),
        .in_h_bp      (cfg_h_bp),
        .in_v_active  (cfg_v_active),
        .in_v_total   (cfg_v_total),
        .in_v_bp      (cfg_v_bp),
        .in_h_sw      (cfg_sync_width[XW-1:0]),
        .in_v_sw      (cfg_sync_width[XW+YW-1:XW]),
        .sh_interlace (sh_interlace),
        .sh_trim      (sh_trim),
        .sh_hinv      (sh_hinv),
        .sh_vinv      (sh_vinv),
        .sh_h_active  (sh_h_active),
        .sh_h_total   (sh_h_total),
        .sh_h_bp      (sh_h_bp),
        .sh_v_active  (sh_v_active),
        .sh_v_total   (sh_v_total),
        .sh_v_bp      (sh_v_bp),
        .sh_h_sw      (sh_h_sw),
        .sh_v_sw      (sh_v_sw)
    );

    dtg_counter #(.XW(XW), .YW(YW)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_enable),
        .interlace   (sh_interlace),
        .h_total     (sh_h_total),
        .lines_total (lines_total),
        .run_q       (run_q),
        .hcnt        (x_o),
        .line        (y_o),
        .field_q     (field_q),
        .frame_wrap  (frame_wrap)
    );

    dtg_decode #(.XW(XW), .YW(YW)) u_decode (
        .run       (run_q),
        .interlace (sh_interlace),
        .field_q   (field_q),
        .hinv      (sh_hinv),
        .vinv      (sh_vinv),
        .hcnt      (x_o),
        .line      (y_o),
        .h_total   (sh_h_total),
        .h_active  (sh_h_active),
        .h_bp      (sh_h_bp),
        .h_sw      (sh_h_sw),
        .v_active  (sh_v_active),
        .v_bp      (sh_v_bp),
        .v_sw      (sh_v_sw),
        .hsync     (hsync_o),
        .vsync     (vsync_o),
        .de        (de_o),
        .field     (field_o)
    );

    dtg_delay #(.YW(YW)) u_delay (
        .interlace   (sh_interlace),
        .trim        (sh_trim),
        .lines_total (lines_total),
        .v_active    (sh_v_active),
        .delay       (line_delay_o)
    );

endmodule

// File: rtl/dtg_checker.sv
// Temporal checks on the timing generator ports, bound to the top module.
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_enable,
    input logic                   cfg_hsync_inv,
    input logic                   cfg_vsync_inv,
    input logic [XW-1:0]          x_o,
    input logic [YW-1:0]          y_o,
    input logic                   hsync_o,
    input logic                   vsync_o,
    input logic                   de_o,
    input logic                   field_o,
    input logic [DTG_DELAY_W-1:0] line_delay_o
);

    AST_DE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !de_o); // R1

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && x_o != '0) |-> (x_o == $past(x_o) + XW'(1))); // R2

    AST_FIELD_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_o) |-> (x_o == '0 && y_o == '0)); // R6

    AST_HSYNC_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (hsync_o == $past(cfg_hsync_inv))); // R8

    AST_VSYNC_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (vsync_o == $past(cfg_vsync_inv))); // R8

    AST_DELAY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        line_delay_o <= DTG_DELAY_W'(DTG_DELAY_CAP)); // R9

endmodule

bind disp_timing_gen dtg_checker #(.XW(XW), .YW(YW)) u_dtg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .cfg_hsync_inv (cfg_hsync_inv),
    .cfg_vsync_inv (cfg_vsync_inv),
    .x_o           (x_o),
    .y_o           (y_o),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .de_o          (de_o),
    .field_o       (field_o),
    .line_delay_o  (line_delay_o)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
// Bench for the raster timing generator: table-driven configurations,
// then directed tests for reset, mid-field reconfiguration and enable restart.
module tb_disp_timing_gen;

    localparam int XW = 12;
    localparam int YW = 12;

    typedef struct packed {
        logic [11:0] ht, ha, hbp, hsw, vt, va, vbp, vsw;
        logic        il, trim, hinv, vinv;
        logic [4:0]  dly;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{12'd20, 12'd12, 12'd5, 12'd2, 12'd22, 12'd6, 12'd3, 12'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5},
        '{12'd16, 12'd8,  12'd4, 12'd3, 12'd9,  12'd8, 12'd2, 12'd2, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0},
        '{12'd10, 12'd4,  12'd3, 12'd1, 12'd80, 12'd2, 12'd2, 12'd2, 1'b0, 1'b1, 1'b1, 1'b1, 5'd30},
        '{12'd12, 12'd6,  12'd4, 12'd2, 12'd24, 12'd4, 12'd3, 12'd2, 1'b0, 1'b1, 1'b0, 1'b1, 5'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_enable, cfg_interlace, cfg_trim, cfg_hsync_inv, cfg_vsync_inv;
    logic [XW-1:0] cfg_h_active, cfg_h_total, cfg_h_bp;
    logic [YW-1:0] cfg_v_active, cfg_v_total, cfg_v_bp;
    logic [XW+YW-1:0] cfg_sync_width;
    logic [XW-1:0] x_o;
    logic [YW-1:0] y_o;
    logic          hsync_o, vsync_o, de_o, field_o;
    logic [4:0]    line_delay_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    vec_t cur, pend;
    int   ex, ey;
    logic ef;

    always #10 clk = ~clk;

    disp_timing_gen #(.XW(XW), .YW(YW)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (x=%0d y=%0d)", tag, act, exp, ex, ey);
        end
    endtask

    task automatic apply(input vec_t v);
        cfg_interlace  = v.il;
        cfg_trim       = v.trim;
        cfg_hsync_inv  = v.hinv;
        cfg_vsync_inv  = v.vinv;
        cfg_h_active   = v.ha;
        cfg_h_total    = v.ht;
        cfg_h_bp       = v.hbp;
        cfg_v_active   = v.va;
        cfg_v_total    = v.vt;
        cfg_v_bp       = v.vbp;
        cfg_sync_width = {v.vsw, v.hsw};
    endtask

    function automatic int lines_of(input vec_t v);
        return v.il ? int'(v.vt) : int'(v.vt) / 2;
    endfunction

    // Compare every output against the bench's own position model.
    task automatic check_pos();
        int  half, act_h;
        logic hs, vs, de;
        half  = int'(cur.ht) / 2;
        act_h = cur.il ? int'(cur.va) / 2 : int'(cur.va);
        hs = (ex < int'(cur.hsw));
        if (cur.il && ef)
            vs = (ey == 0 && ex >= half) || (ey > 0 && ey < int'(cur.vsw)) ||
                 (ey == int'(cur.vsw) && ex < half);
        else
            vs = (ey < int'(cur.vsw));
        de = (ex >= int'(cur.hbp)) && (ex < int'(cur.hbp) + int'(cur.ha)) &&
             (ey >= int'(cur.vbp)) && (ey < int'(cur.vbp) + act_h);
        chk("R2 x position", int'(x_o), ex);
        chk("R4 y position", int'(y_o), ey);
        chk("R3/R8 hsync", int'(hsync_o), int'(hs ^ cur.hinv));
        chk("R7/R8 vsync", int'(vsync_o), int'(vs ^ cur.vinv));
        chk("R5 data enable", int'(de_o), int'(de));
        chk("R6 field", int'(field_o), int'(ef));
        chk("R9 line delay", int'(line_delay_o), int'(cur.dly));
    endtask

    // Advance the model by one pixel; R10: pending setup adopted only at the wrap.
    task automatic step();
        ex++;
        if (ex == int'(cur.ht)) begin
            ex = 0;
            ey++;
            if (ey == lines_of(cur)) begin
                ey = 0;
                ef = cur.il ? ~ef : 1'b0;
                cur = pend;
            end
        end
    endtask

    task automatic run_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_pos();
            step();
        end
    endtask

    task automatic start(input vec_t v);
        apply(v);
        cfg_enable = 1'b1;
        cur = v; pend = v;
        ex = 0; ey = 0; ef = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_enable = 1'b0;
        apply('0);
        repeat (4) @(negedge clk);
        // R1: reset / idle state
        chk("R1 reset x", int'(x_o), 0);
        chk("R1 reset y", int'(y_o), 0);
        chk("R1 reset de", int'(de_o), 0);
        chk("R1 reset field", int'(field_o), 0);
        chk("R1 reset hsync", int'(hsync_o), 0);
        rst_n = 1'b1;

        // Table walk: idle levels, then two fields of scanning per entry.
        for (int k = 0; k < NV; k++) begin
            cfg_enable = 1'b0;
            apply(VECS[k]);
            repeat (2) @(negedge clk);
            chk("R1/R8 idle hsync level", int'(hsync_o), int'(VECS[k].hinv));
            chk("R1/R8 idle vsync level", int'(vsync_o), int'(VECS[k].vinv));
            chk("R1 idle de", int'(de_o), 0);
            chk("R9 idle delay", int'(line_delay_o), int'(VECS[k].dly));
            start(VECS[k]);
            run_cycles(2 * int'(VECS[k].ht) * lines_of(VECS[k]) + 7);
        end

        // R10: reconfigure mid-field; old geometry until the wrap.
        cfg_enable = 1'b0;
        apply(VECS[0]);
        repeat (2) @(negedge clk);
        start(VECS[0]);
        run_cycles(50);
        apply(VECS[3]);
        pend = VECS[3];
        run_cycles(int'(VECS[0].ht) * lines_of(VECS[0]) + int'(VECS[3].ht) * lines_of(VECS[3]));

        // R1 then R11: drop enable mid-field, then restart at the origin.
        cfg_enable = 1'b0;
        @(negedge clk);
        chk("R1 drop x", int'(x_o), 0);
        chk("R1 drop y", int'(y_o), 0);
        chk("R1 drop de", int'(de_o), 0);
        chk("R1 drop field", int'(field_o), 0);
        chk("R1 drop hsync", int'(hsync_o), int'(VECS[3].hinv));
        chk("R1 drop vsync", int'(vsync_o), int'(VECS[3].vinv));
        start(VECS[1]);
        @(negedge clk);
        chk("R11 restart x", int'(x_o), 0);
        chk("R11 restart y", int'(y_o), 0);
        chk("R11 restart field", int'(field_o), 0);
        check_pos();
        step();
        run_cycles(3 * int'(VECS[1].ht) * lines_of(VECS[1]));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule